// File: doc/BRIEF.md
# Indirect Interrupt Routing Register Front End

This block gives a processor access to a large internal register space of an interrupt router through just two bus locations: a selector location that holds a register number, and a data window through which the selected register is read or written. Only the low eight address bits are decoded. The register space holds an identifier register, a read-only version register, an arbitration register that always reads zero, and a table of 64-bit routing entries, one per input pin. Each 64-bit entry is reached as two 32-bit halves through consecutive selector values.

The routing table lives inside the block. Every write that lands in a table half also produces a one-cycle service pulse so that a separate delivery engine can rescan the table. The table contents are exported in full for that engine. Delivery itself is not part of this block.

Top module: `irq_route_regs`

## Requirements
- R1: Bus address bits [7:0] alone select the location: 0x00 is the selector, 0x10 is the data window; bits above 7 are ignored.
- R2: A write to the selector stores the low SEL_W bits of the write data; a read of the selector returns that stored value, zero-extended.
- R3: A data window access with a size code other than 4 bytes (size input not equal to 2) writes nothing and reads zero.
- R4: Selector 0x00 is the identifier: a window write stores write data bits [27:24]; a window read returns the stored 4-bit ID in bits [27:24] and zero elsewhere. Reset ID is 0.
- R5: Selector 0x01 reads as 0x11 | ((NUM_PINS-1) << 16); selector 0x02 reads as zero; window writes to either change nothing.
- R6: For selector values from 0x10 upward, the entry index is (selector - 0x10) >> 1; an even selector reaches entry bits [31:0], an odd one bits [63:32]. Reads return that half.
- R7: A window write to an entry half replaces only that half and leaves the other half and all other entries unchanged; the updated entry appears on the table output on the next cycle.
- R8: A window write to an in-range entry half raises the service pulse for exactly one cycle, in the cycle after the write; no other access raises it.
- R9: A selector whose index is NUM_PINS or more, or any value 0x03 to 0x0F, reads zero through the window and ignores writes.
- R10: Reads of any offset other than 0x00 and 0x10 return zero; writes to them change nothing. Read data is combinational from the current state.
- R11: After reset the selector, ID and every table entry are zero, except that each entry's mask bit (bit 16) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe (read data is valid whenever address is stable) |
| bus_size | input | 2 | Access size code: 0=1 byte, 1=2 bytes, 2=4 bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| tbl_flat | output | NUM_PINS*64 | All routing entries, entry n in bits [n*64+63:n*64] |
| svc_pulse | output | 1 | One-cycle request to the delivery engine to rescan |

## Verification
A corrupted selector shows at once as wrong read data from the selector location, and on the next window access as the wrong register or half. A wrong half-merge or index decode shows on the table output one cycle after the write and in the window read that follows, so every write is read back both through the bus and the table output. A missing or extra service pulse shows in the single cycle after a write, so the pulse is sampled in that cycle and the one after.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
   localparam logic [7:0] OFS_SEL = 8'h00;
   localparam logic [7:0] OFS_WIN = 8'h10;
   localparam logic [7:0] REG_ID  = 8'h00;
   localparam logic [7:0] REG_VER = 8'h01;
   localparam logic [7:0] REG_ARB = 8'h02;
   localparam logic [7:0] TBL_BASE = 8'h10;
   localparam logic [7:0] VER_CONST = 8'h11;
   localparam int ID_LSB = 24;
   localparam int ID_W = 4;
   localparam int MAXENT_LSB = 16;
   localparam int MASK_BIT = 16;
   localparam logic [1:0] SIZE_WORD = 2'd2;

   typedef enum logic [2:0] {
      K_NONE, K_ID, K_VER, K_ARB, K_ENTRY
   } reg_kind_e;
endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
   import irq_route_pkg::*;
#(
   parameter int SEL_W = 8,
   parameter int NUM_PINS = 24,
   localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
   input  logic [SEL_W-1:0] sel,
   output reg_kind_e        kind,
   output logic [IDX_W-1:0] idx,
   output logic             hi_half
);
   logic [SEL_W-1:0] rel;
   logic [SEL_W-1:0] full_idx;

   always_comb begin
      rel = sel - SEL_W'(TBL_BASE);
      full_idx = rel >> 1;
      hi_half = sel[0];
      idx = full_idx[IDX_W-1:0];
      if (sel == SEL_W'(REG_ID))       kind = K_ID;
      else if (sel == SEL_W'(REG_VER)) kind = K_VER;
      else if (sel == SEL_W'(REG_ARB)) kind = K_ARB;
      else if (sel >= SEL_W'(TBL_BASE) && full_idx < SEL_W'(NUM_PINS)) kind = K_ENTRY;
      else kind = K_NONE;
   end
endmodule

// File: rtl/irq_route_table.sv
module irq_route_table
   import irq_route_pkg::*;
#(
   parameter int NUM_PINS = 24,
   localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [IDX_W-1:0]      wr_idx,
   input  logic                  wr_hi,
   input  logic [31:0]           wr_data,
   input  logic [IDX_W-1:0]      rd_idx,
   input  logic                  rd_hi,
   output logic [31:0]           rd_data,
   output logic [NUM_PINS*64-1:0] flat,
   output logic                  svc
);
   logic [63:0] ent [NUM_PINS];

   for (genvar g = 0; g < NUM_PINS; g++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent[g] <= 64'(1) << MASK_BIT;
         end else if (wr_en && wr_idx == IDX_W'(g)) begin
            if (wr_hi) ent[g][63:32] <= wr_data;
            else       ent[g][31:0]  <= wr_data;
         end
      end
      assign flat[g*64 +: 64] = ent[g];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) svc <= 1'b0;
      else        svc <= wr_en;
   end

   always_comb begin
      rd_data = '0;
      if (32'(rd_idx) < NUM_PINS)
         rd_data = rd_hi ? ent[rd_idx][63:32] : ent[rd_idx][31:0];
   end

   // R8
   svc_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      svc |=> !svc || $past(wr_en));
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
   import irq_route_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int SEL_W = 8,
   parameter int NUM_PINS = 24,
   localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic                   bus_wr,
   input  logic                   bus_rd,
   input  logic [1:0]             bus_size,
   input  logic [31:0]            bus_wdata,
   output logic [31:0]            bus_rdata,
   output logic [NUM_PINS*64-1:0] tbl_flat,
   output logic                   svc_pulse
);
   initial begin
      assert (ADDR_W >= 8) else $error("ADDR_W must cover 8 decode bits");
      assert (SEL_W >= 8 && SEL_W <= 32) else $error("SEL_W out of range");
      assert (NUM_PINS >= 1 && NUM_PINS <= 120) else $error("NUM_PINS out of range");
   end

   logic [SEL_W-1:0] sel_q;
   logic [ID_W-1:0]  id_q;
   reg_kind_e        kind;
   logic [IDX_W-1:0] idx;
   logic             hi;
   logic [31:0]      ent_rd;
   logic [7:0]       ofs;
   logic             at_sel, at_win, win_ok, ent_wr;
   logic             rd_unused;

   assign ofs = bus_addr[7:0];
   assign at_sel = ofs == OFS_SEL;
   assign at_win = ofs == OFS_WIN;
   assign win_ok = at_win && bus_size == SIZE_WORD;
   assign rd_unused = bus_rd;

   irq_route_decode #(.SEL_W(SEL_W), .NUM_PINS(NUM_PINS)) u_dec (
      .sel(sel_q), .kind(kind), .idx(idx), .hi_half(hi)
   );

   assign ent_wr = bus_wr && win_ok && kind == K_ENTRY;

   irq_route_table #(.NUM_PINS(NUM_PINS)) u_tbl (
      .clk(clk), .rst_n(rst_n), .wr_en(ent_wr), .wr_idx(idx), .wr_hi(hi),
      .wr_data(bus_wdata), .rd_idx(idx), .rd_hi(hi), .rd_data(ent_rd),
      .flat(tbl_flat), .svc(svc_pulse)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q <= '0;
         id_q  <= '0;
      end else if (bus_wr) begin
         if (at_sel) sel_q <= bus_wdata[SEL_W-1:0];
         if (win_ok && kind == K_ID) id_q <= bus_wdata[ID_LSB +: ID_W];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (at_sel) begin
         bus_rdata = 32'(sel_q);
      end else if (win_ok) begin
         unique case (kind)
            K_ID:    bus_rdata = 32'(id_q) << ID_LSB;
            K_VER:   bus_rdata = 32'(VER_CONST) | (32'(NUM_PINS - 1) << MAXENT_LSB);
            K_ENTRY: bus_rdata = ent_rd;
            default: bus_rdata = '0;
         endcase
      end
   end

   // R3
   narrow_win_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (at_win && bus_size != SIZE_WORD) |-> bus_rdata == 32'd0);
   // R8
   svc_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ent_wr |=> svc_pulse);
   // R2
   sel_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && at_sel) |=> $stable(sel_q));
   // R5
   ver_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_ok && kind == K_VER) |-> bus_rdata[7:0] == VER_CONST);
   // R10
   other_ofs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!at_sel && !at_win) |-> bus_rdata == 32'd0);
endmodule

// File: tb/irq_route_regs_test.sv
module irq_route_regs_test;
   localparam int NP = 24;
   logic clk = 0, rst_n = 0;
   logic [11:0] addr = 0;
   logic wr = 0, rd = 0;
   logic [1:0] size = 2;
   logic [31:0] wdata = 0;
   logic [31:0] rdata;
   logic [NP*64-1:0] flat;
   logic svc;
   int tests = 0, fails = 0;

   irq_route_regs #(.NUM_PINS(NP)) uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
      .bus_size(size), .bus_wdata(wdata), .bus_rdata(rdata),
      .tbl_flat(flat), .svc_pulse(svc));

   always #2 clk = ~clk;

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // write: drive at negedge, edge at posedge, deassert at next negedge
   task automatic bwr(logic [11:0] a, logic [31:0] d, logic [1:0] s = 2);
      @(negedge clk); addr = a; wdata = d; size = s; wr = 1;
      @(negedge clk); wr = 0; size = 2;
   endtask

   task automatic brd(logic [11:0] a, output logic [31:0] d, input logic [1:0] s = 2);
      @(negedge clk); addr = a; size = s; rd = 1; #1 d = rdata; rd = 0; size = 2;
   endtask

   task automatic rdreg(logic [7:0] r, output logic [31:0] d);
      bwr(12'h000, {24'd0, r});
      brd(12'h010, d);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      brd(12'h000, d); chk("R11 sel", d, 0);
      rdreg(8'h00, d); chk("R11 id", d, 0);
      chk("R11 entry0", flat[63:0], 64'h10000);
      chk("R11 entry23", flat[23*64 +: 64], 64'h10000);
      chk("R8 idle", svc, 0);
   endtask

   task automatic t_select;
      logic [31:0] d;
      bwr(12'h000, 32'hFFFF_FF5A); brd(12'h000, d); chk("R2 sel", d, 32'h5A);
      bwr(12'hF00, 32'h33); brd(12'h700, d); chk("R1 high bits ignored", d, 32'h33);
   endtask

   task automatic t_id_ver;
      logic [31:0] d;
      bwr(12'h000, 0); bwr(12'h010, 32'hFFFF_FFFF);
      brd(12'h010, d); chk("R4 id", d, 32'h0F00_0000);
      bwr(12'h010, 32'h0300_0000, 2'd1);
      brd(12'h010, d); chk("R3 narrow write ignored", d, 32'h0F00_0000);
      brd(12'h010, d, 2'd0); chk("R3 narrow read zero", d, 0);
      rdreg(8'h01, d); chk("R5 version", d, 32'h0017_0011);
      bwr(12'h010, 0); brd(12'h010, d); chk("R5 version write ignored", d, 32'h0017_0011);
      rdreg(8'h02, d); chk("R5 arb", d, 0);
      bwr(12'h010, 32'hFFFF_FFFF); brd(12'h010, d); chk("R5 arb write ignored", d, 0);
   endtask

   task automatic t_entry;
      logic [31:0] d;
      // entry 3 low = sel 0x16, high = sel 0x17
      bwr(12'h000, 32'h16);
      @(negedge clk); addr = 12'h010; wdata = 32'hA5A5_0031; wr = 1;
      @(negedge clk); wr = 0; chk("R8 pulse", svc, 1);
      @(negedge clk); chk("R8 pulse one cycle", svc, 0);
      chk("R7 low half", flat[3*64 +: 64], 64'h0000_0000_A5A5_0031);
      bwr(12'h000, 32'h17); bwr(12'h010, 32'hDEAD_BEEF);
      chk("R7 merge", flat[3*64 +: 64], 64'hDEAD_BEEF_A5A5_0031);
      chk("R7 neighbour", flat[2*64 +: 64], 64'h10000);
      brd(12'h010, d); chk("R6 odd reads high", d, 32'hDEAD_BEEF);
      rdreg(8'h16, d); chk("R6 even reads low", d, 32'hA5A5_0031);
      rdreg(8'h3F, d); chk("R6 last entry high", d, 0);
      rdreg(8'h3E, d); chk("R6 last entry low", d, 32'h10000);
   endtask

   task automatic t_out_of_range;
      logic [31:0] d;
      logic [NP*64-1:0] snap;
      snap = flat;
      bwr(12'h000, 32'h40);
      @(negedge clk); addr = 12'h010; wdata = 32'h1234_5678; wr = 1;
      @(negedge clk); wr = 0; chk("R9 no pulse", svc, 0);
      chk("R9 table unchanged", 64'(flat == snap), 1);
      brd(12'h010, d); chk("R9 read zero", d, 0);
      rdreg(8'h05, d); chk("R9 gap reg zero", d, 0);
      bwr(12'h010, 32'hFFFF_FFFF);
      chk("R9 gap write no table change", 64'(flat == snap), 1);
      bwr(12'h004, 32'hFFFF_FFFF);
      brd(12'h004, d); chk("R10 other offset zero", d, 0);
      brd(12'h000, d); chk("R10 selector untouched", d, 32'h05);
      bwr(12'h000, 0); brd(12'h010, d); chk("R10 id untouched", d, 32'h0F00_0000);
      chk("R10 table untouched", 64'(flat == snap), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_select();
      t_id_ver();
      t_entry();
      t_out_of_range();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #200000;
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule